// File: doc/BRIEF.md
# Sigma-Delta RGB Indicator Driver

This block drives the three pins of an RGB indicator LED. Each pin is dimmed by first-order pulse density modulation instead of a PWM counter. A tick strobe is divided down from the system clock at `TICK_HZ`. On every tick, each colour channel adds its level to an accumulator. The pin goes high only on the ticks where the sum carries past 256. Before modulation, every colour byte is multiplied by a global brightness byte and rounded back into the 0..255 range.

A millisecond event is derived from the tick rate by fractional accumulation, so no second divider is needed. Each millisecond moves a fixed-point hue position around a 1536-step colour wheel. The wheel is integer-only and is made of six 256-step segments. The wheel gives the idle colour. When the override enable is set, an externally supplied colour is used instead of the wheel colour. The wheel keeps turning while the override is on.

Top module: `led_pdm_driver`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `led_o` is 0. Reset clears the tick divider, the millisecond accumulator, the hue position and all three channel accumulators.
- R2: On each tick, a channel adds its scaled level to its 16-bit accumulator. If the sum is 256 or more, the pin goes high and 256 is subtracted. Otherwise the pin goes low and the sum is kept. The accumulator always stays below 256.
- R3: A tick occurs once every `CLK_HZ/TICK_HZ` clocks. The first tick is on clock edge `CLK_HZ/TICK_HZ` after reset. `led_o` changes only in the cycle after a tick.
- R4: The level fed to a channel is `(colour*scale + 127)/255`, using integer division. A `scale` of 0 keeps every pin low. A `scale` of 64 maps colour 255 to level 64.
- R5: Over any 256 consecutive ticks with a constant level L, the pin is high on exactly L ticks.
- R6: On each tick, 1000 is added to the millisecond accumulator. When the result reaches `TICK_HZ`, `TICK_HZ` is subtracted and a millisecond event fires in that same tick.
- R7: When `ovr_en` is 1, the colour comes from `ovr_rgb`: red in [23:16], green in [15:8] and blue in [7:0]. Pin bit 0 is red, bit 1 is green and bit 2 is blue.
- R8: The hue is an unsigned 16.16 value. On each millisecond event it advances by `(1536<<16)/PERIOD_MS`, wrapping modulo `1536<<16`.
- R9: The wheel colour uses the step index `i = hue>>16`, segment `s = i/256` and fraction `f = i%256`:
  - s0: (255, f, 0)
  - s1: (255-f, 255, 0)
  - s2: (0, 255, f)
  - s3: (0, 255-f, 255)
  - s4: (f, 0, 255)
  - s5: (255, 0, 255-f)

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ovr_en | input | 1 | Use `ovr_rgb` instead of the hue wheel |
| ovr_rgb | input | 24 | Override colour {red, green, blue} |
| scale | input | 8 | Global brightness, 0..255 |
| led_o | output | 3 | Pin levels {blue, green, red} |

## Verification
The checks assume that `rst` is asserted from time zero, so that no property sees uninitialised accumulators. They also assume that `scale` and `ovr_rgb` are sampled only at clock edges. The bench changes inputs only on falling edges and starts with reset held. The properties about a dark channel take the stimulus as given in the tick cycle and look one cycle ahead. The bench therefore holds zero colours and zero brightness across several ticks.

// File: rtl/led_pdm_driver.sv
module led_pdm_driver #(
  parameter int CLK_HZ    = 48_000_000,
  parameter int TICK_HZ   = 20_000,
  parameter int PERIOD_MS = 8000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ovr_en,
  input  logic [23:0] ovr_rgb,
  input  logic [7:0]  scale,
  output logic [2:0]  led_o
);
  localparam logic [31:0] DIV     = 32'(CLK_HZ / TICK_HZ);
  localparam logic [31:0] RATE    = 32'(TICK_HZ);
  localparam logic [26:0] HUE_MOD = 27'(1536) << 16;
  localparam logic [26:0] STEP    = 27'(HUE_MOD / 27'(PERIOD_MS));

  logic [31:0] div_q, ms_q, ms_sum;
  logic        tick, ms_evt;
  logic [26:0] hue_q, hue_sum, hue_nx;
  logic [10:0] idx;
  logic [2:0]  seg;
  logic [7:0]  f;
  logic [7:0]  anim [3];
  logic [7:0]  tgt  [3];
  logic [7:0]  lvl  [3];
  logic [15:0] acc_q [3];

  assign tick    = (div_q == DIV - 32'd1);
  assign ms_sum  = ms_q + 32'd1000;
  assign ms_evt  = tick && (ms_sum >= RATE);
  assign hue_sum = hue_q + STEP;
  assign hue_nx  = (hue_sum >= HUE_MOD) ? hue_sum - HUE_MOD : hue_sum;
  assign idx     = hue_q[26:16];
  assign seg     = idx[10:8];
  assign f       = idx[7:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      ms_q  <= '0;
      hue_q <= '0;
    end else begin
      div_q <= tick ? '0 : div_q + 32'd1;
      if (tick) ms_q <= ms_evt ? ms_sum - RATE : ms_sum;
      if (ms_evt) hue_q <= hue_nx;
    end
  end

  always_comb begin
    anim[0] = 8'd0;
    anim[1] = 8'd0;
    anim[2] = 8'd0;
    case (seg)
      3'd0: begin anim[0] = 8'd255; anim[1] = f;      end
      3'd1: begin anim[0] = ~f;     anim[1] = 8'd255; end
      3'd2: begin anim[1] = 8'd255; anim[2] = f;      end
      3'd3: begin anim[1] = ~f;     anim[2] = 8'd255; end
      3'd4: begin anim[0] = f;      anim[2] = 8'd255; end
      default: begin anim[0] = 8'd255; anim[2] = ~f;  end
    endcase
  end

  for (genvar i = 0; i < 3; i++) begin : g_ch
    logic [16:0] prod;
    logic [15:0] sum;
    assign tgt[i] = ovr_en ? ovr_rgb[23 - 8*i -: 8] : anim[i];
    assign prod   = 17'(tgt[i]) * 17'(scale) + 17'd127;
    assign lvl[i] = 8'(prod / 17'd255);
    assign sum    = acc_q[i] + {8'd0, lvl[i]};

    always_ff @(posedge clk) begin
      if (rst) begin
        acc_q[i] <= '0;
        led_o[i] <= 1'b0;
      end else if (tick) begin
        if (sum >= 16'd256) begin
          acc_q[i] <= sum - 16'd256;
          led_o[i] <= 1'b1;
        end else begin
          acc_q[i] <= sum;
          led_o[i] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/led_pdm_chk.sv
module led_pdm_chk #(
  parameter int TICK_HZ = 20_000
) (
  input logic        clk,
  input logic        rst,
  input logic        tick,
  input logic        ovr_en,
  input logic [23:0] ovr_rgb,
  input logic [7:0]  scale,
  input logic [2:0]  led_o,
  input logic [31:0] ms_q,
  input logic [26:0] hue_q,
  input logic [15:0] acc0,
  input logic [15:0] acc1,
  input logic [15:0] acc2
);
  // R1
  reset_dark_chk: assert property (@(posedge clk) rst |=> led_o == 3'b000);

  // R2
  acc_bound_chk: assert property (@(posedge clk) disable iff (rst)
    acc0 < 16'd256 && acc1 < 16'd256 && acc2 < 16'd256);

  // R3
  hold_between_ticks_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(led_o));

  // R4
  zero_scale_dark_chk: assert property (@(posedge clk) disable iff (rst)
    tick && scale == 8'd0 |=> led_o == 3'b000);

  // R6
  ms_bound_chk: assert property (@(posedge clk) disable iff (rst)
    ms_q < 32'(TICK_HZ));

  // R7
  ovr_black_chk: assert property (@(posedge clk) disable iff (rst)
    tick && ovr_en && ovr_rgb == 24'd0 |=> led_o == 3'b000);

  // R8
  hue_bound_chk: assert property (@(posedge clk) disable iff (rst)
    hue_q < (27'(1536) << 16));
endmodule

bind led_pdm_driver led_pdm_chk #(.TICK_HZ(TICK_HZ)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .ovr_en(ovr_en), .ovr_rgb(ovr_rgb),
  .scale(scale), .led_o(led_o), .ms_q(ms_q), .hue_q(hue_q),
  .acc0(acc_q[0]), .acc1(acc_q[1]), .acc2(acc_q[2])
);

// File: tb/sim_led_pdm_driver.sv
module sim_led_pdm_driver;
  localparam int CLK_HZ = 40_000, TICK_HZ = 20_000, PERIOD_MS = 96;
  localparam int DIV = CLK_HZ / TICK_HZ;
  localparam int HMOD = 1536 * 65536;
  localparam int STEP = HMOD / PERIOD_MS;

  logic clk = 1'b0, rst = 1'b1, ovr_en = 1'b0;
  logic [23:0] ovr_rgb = '0;
  logic [7:0] scale = 8'd255;
  logic [2:0] led_o;
  int checks = 0, errors = 0;
  bit cmp_on = 0;

  always #2 clk = ~clk;

  led_pdm_driver #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ), .PERIOD_MS(PERIOD_MS)) u0 (
    .clk(clk), .rst(rst), .ovr_en(ovr_en), .ovr_rgb(ovr_rgb),
    .scale(scale), .led_o(led_o));

  // behavioural reference
  int m_div, m_ms, m_hue;
  int m_acc [3];
  logic [2:0] m_led;

  function automatic int wheel(int hue, int ch);
    int i, s, f;
    int c [3];
    i = hue / 65536; s = i / 256; f = i % 256;
    case (s)
      0: c = '{255, f, 0};
      1: c = '{255 - f, 255, 0};
      2: c = '{0, 255, f};
      3: c = '{0, 255 - f, 255};
      4: c = '{f, 0, 255};
      default: c = '{255, 0, 255 - f};
    endcase
    return c[ch];
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_div = 0; m_ms = 0; m_hue = 0; m_led = 0;
      foreach (m_acc[k]) m_acc[k] = 0;
    end else if (m_div == DIV - 1) begin
      m_div = 0;
      for (int c = 0; c < 3; c++) begin
        int t, l;
        t = ovr_en ? int'(ovr_rgb[23 - 8*c -: 8]) : wheel(m_hue, c);
        l = (t * int'(scale) + 127) / 255;
        m_acc[c] += l;
        if (m_acc[c] >= 256) begin m_acc[c] -= 256; m_led[c] = 1'b1; end
        else m_led[c] = 1'b0;
      end
      m_ms += 1000;
      if (m_ms >= TICK_HZ) begin
        m_ms -= TICK_HZ;
        m_hue = (m_hue + STEP) % HMOD;
      end
    end else m_div++;
  end

  always @(negedge clk) if (cmp_on) begin
    checks++;
    if (led_o !== m_led) begin
      errors++;
      $display("FAIL R2 R3 R6 R8 R9 model: led_o=%b expected %b at %0t", led_o, m_led, $time);
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic count_highs(int n, output int h [3]);
    h = '{0, 0, 0};
    repeat (n) begin
      @(negedge clk);
      for (int c = 0; c < 3; c++) h[c] += led_o[c];
    end
  endtask

  function automatic bit near(int a, int e);
    return (a >= e - 2) && (a <= e + 2);
  endfunction

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int h [3];
    repeat (3) @(negedge clk);
    check(led_o == 3'b000, "R1 reset dark", int'(led_o), 0);
    rst = 1'b0;
    @(negedge clk);
    check(led_o == 3'b000, "R1 first cycle after reset", int'(led_o), 0);
    cmp_on = 1;

    // r9_ first millisecond: hue 0 gives pure red, green and blue dark
    count_highs(36, h);
    check(h[1] == 0 && h[2] == 0, "R9 hue zero is red only", h[1] + h[2], 0);
    check(h[0] > 0, "R9 hue zero red active", h[0], 1);

    // R5 R7 duty with override at full scale
    ovr_en = 1'b1; ovr_rgb = {8'd128, 8'd0, 8'd255};
    repeat (DIV * 300) @(negedge clk);
    count_highs(DIV * 256, h);
    check(near(h[0], DIV * 128), "R5 red 128 duty", h[0], DIV * 128);
    check(h[1] == 0, "R7 green 0 dark", h[1], 0);
    check(near(h[2], DIV * 255), "R5 blue 255 duty", h[2], DIV * 255);

    // R4 scale 64 maps 255 to 64
    scale = 8'd64; ovr_rgb = {8'd255, 8'd255, 8'd1};
    repeat (DIV * 300) @(negedge clk);
    count_highs(DIV * 256, h);
    check(near(h[0], DIV * 64), "R4 scale 64 red", h[0], DIV * 64);
    check(near(h[1], DIV * 64), "R4 scale 64 green", h[1], DIV * 64);
    check(h[2] == 0, "R4 rounding 1*64 is 0", h[2], 0);

    // R4 scale 0 keeps dark
    scale = 8'd0; ovr_rgb = 24'hFFFFFF;
    repeat (DIV * 2) @(negedge clk);
    count_highs(DIV * 200, h);
    check(h[0] + h[1] + h[2] == 0, "R4 zero scale dark", h[0] + h[1] + h[2], 0);

    // R7 override black
    scale = 8'd255; ovr_rgb = 24'd0;
    repeat (DIV * 2) @(negedge clk);
    count_highs(DIV * 200, h);
    check(h[0] + h[1] + h[2] == 0, "R7 override black dark", h[0] + h[1] + h[2], 0);

    // R8 R9 wheel run, more than a full turn, with mid-run brightness changes
    ovr_en = 1'b0;
    repeat (3000) @(negedge clk);
    scale = 8'd100;
    repeat (1500) @(negedge clk);
    scale = 8'd255; ovr_en = 1'b1; ovr_rgb = 24'h40C020;
    repeat (500) @(negedge clk);
    ovr_en = 1'b0;
    count_highs(DIV * 20 * 120, h);
    check(h[0] > 0 && h[1] > 0 && h[2] > 0, "R8 wheel lights every channel",
          h[0] > 0 && h[1] > 0 && h[2] > 0, 1);

    cmp_on = 0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule